// File: doc/BRIEF.md
# Dual-Threshold Over-Current Trip Timer

This block decides when a battery pack's discharge current has been too high for too long. Two comparator flags arrive from the sense-resistor front end. The moderate flag is raised near 110 mV and must persist for a long qualify window of about 7 ms. The severe flag is raised near 300 mV and needs only a short window of about 500 µs. Each flag has its own tick counter. Both counters run at the same time and feed one trip latch. The first counter to reach its terminal count wins. If a flag falls during its window, that counter clears and the pending trip is cancelled.

A trip removes the discharge enable and drops the warning output that tells the host to save its state. Removing the discharge path pulls the pack-side sense line low, and the block then reports shutdown. When the pack-side line returns high (a charger is attached, or the line is driven high), discharge is enabled again and the warning output is asserted again. A separate remote-off input forces both the charge and discharge enables low. Detection keeps running while it is high.

Time is counted in ticks of a shared enable pulse. The two qualify delays are parameters expressed in ticks.

Top module: `oc_trip_timer`

## Requirements
- R1: After reset, with remote_off low, dsg_en=1, chg_en=1, warn_n=1 and shutdown=0.
- R2: If oc_low stays high for LOW_DLY clock cycles that have tick=1, the block trips. dsg_en and warn_n go to 0 in the cycle after the edge that samples the LOW_DLY-th such tick.
- R3: If oc_high stays high for HIGH_DLY ticked cycles, the block trips in the same way. This holds even while the oc_low count is in progress.
- R4: When a flag is low at a clock edge, its count clears. A moderate episode of LOW_DLY-1 ticks that then drops does not trip, and the next episode again needs the full LOW_DLY ticks.
- R5: An oc_high pulse that lasts HIGH_DLY-1 ticked cycles and then drops does not trip.
- R6: Once tripped, dsg_en=0 and warn_n=0 whatever the flags do, until recovery through R8.
- R7: While tripped, a clock edge that sees pack_hi=0 sets shutdown=1 from the next cycle. dsg_en stays 0.
- R8: In shutdown, a clock edge that sees pack_hi=1 returns the block to normal: dsg_en=1, warn_n=1, shutdown=0. Both counts start again from zero.
- R9: While remote_off=1, chg_en=0 and dsg_en=0, and detection and trip continue. With remote_off=0, chg_en=1, and dsg_en=1 unless tripped or in shutdown.
- R10: Cycles with tick=0 do not advance either count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base enable, one pulse per count step |
| oc_low | input | 1 | Moderate over-current comparator flag |
| oc_high | input | 1 | Severe over-current comparator flag |
| pack_hi | input | 1 | Pack-side sense line is at battery level |
| remote_off | input | 1 | Forces charge and discharge enables off |
| dsg_en | output | 1 | Discharge switch enable |
| chg_en | output | 1 | Charge switch enable |
| warn_n | output | 1 | Power-good warning, low after a trip |
| shutdown | output | 1 | Block has entered shutdown |

## Verification
Every cycle, the assertions check these rules: the counts stay within their terminal values, a dropped flag clears its count, a tickless cycle holds the count, a terminal count moves the state to tripped, shutdown is entered only after pack_hi is seen low, and recovery happens only when it is seen high. Some behaviours come only from the bench's scenarios. These are the exact trip cycle when one path overtakes the other, the miss by one tick on each path, and the restart of a cancelled moderate episode. So is the output mapping under remote-off, which is checked against a reference model during random traffic.

// File: rtl/oc_trip_pkg.sv
package oc_trip_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_TRIP = 2'd1,
      ST_OFF  = 2'd2
   } oc_state_t;
endpackage

// File: rtl/oc_qual_timer.sv
module oc_qual_timer #(
   parameter int unsigned DLY = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic flag,
   input  logic tick,
   output logic expire
);
   localparam int unsigned W = $clog2(DLY + 1);
   localparam logic [W-1:0] LAST = W'(DLY - 1);

   generate
      if (DLY < 2) begin : g_bad_dly
         $error("oc_qual_timer: DLY must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt <= '0;
      else if (!arm || !flag)  cnt <= '0;
      else if (tick && cnt != LAST) cnt <= cnt + 1'b1;
   end

   always_comb expire = arm && flag && tick && (cnt == LAST);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);                                               // R2
   AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !flag |=> cnt == '0);                                        // R4
   AST_TICKLESS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && flag && !tick) |=> $stable(cnt));                    // R10
endmodule

// File: rtl/oc_trip_fsm.sv
module oc_trip_fsm
   import oc_trip_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      trip_req,
   input  logic      pack_hi,
   output oc_state_t state
);
   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_RUN;
      else begin
         unique case (state)
            ST_RUN:  if (trip_req) state <= ST_TRIP;
            ST_TRIP: if (!pack_hi) state <= ST_OFF;
            ST_OFF:  if (pack_hi)  state <= ST_RUN;
            default: state <= ST_RUN;
         endcase
      end
   end

   AST_TRIP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && trip_req) |=> state == ST_TRIP);         // R2
   AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TRIP && pack_hi) |=> state == ST_TRIP);         // R6
   AST_OFF_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(state == ST_OFF) |-> !$past(pack_hi));                 // R7
   AST_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OFF && pack_hi) |=> state == ST_RUN);           // R8
endmodule

// File: rtl/oc_trip_timer.sv
module oc_trip_timer
   import oc_trip_pkg::*;
#(
   parameter int unsigned LOW_DLY  = 70,
   parameter int unsigned HIGH_DLY = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic oc_low,
   input  logic oc_high,
   input  logic pack_hi,
   input  logic remote_off,
   output logic dsg_en,
   output logic chg_en,
   output logic warn_n,
   output logic shutdown
);
   generate
      if (HIGH_DLY >= LOW_DLY) begin : g_bad_order
         $error("oc_trip_timer: HIGH_DLY must be shorter than LOW_DLY");
      end
   endgenerate

   localparam int NPATH = 2;
   localparam int unsigned DLYS [NPATH] = '{LOW_DLY, HIGH_DLY};

   oc_state_t        state;
   logic [NPATH-1:0] flags;
   logic [NPATH-1:0] expire;
   logic             armed;

   assign flags = {oc_high, oc_low};
   assign armed = (state == ST_RUN);

   for (genvar i = 0; i < NPATH; i++) begin : g_path
      oc_qual_timer #(.DLY(DLYS[i])) u_tmr (
         .clk   (clk),
         .rst_n (rst_n),
         .arm   (armed),
         .flag  (flags[i]),
         .tick  (tick),
         .expire(expire[i])
      );
   end

   oc_trip_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .trip_req(|expire),
      .pack_hi (pack_hi),
      .state   (state)
   );

   always_comb begin
      warn_n   = armed;
      shutdown = (state == ST_OFF);
      chg_en   = !remote_off;
      dsg_en   = armed && !remote_off;
   end

   AST_DSG_NEEDS_WARN: assert property (@(posedge clk) disable iff (!rst_n)
      dsg_en |-> warn_n);                                          // R6
   AST_REMOTE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      remote_off |-> (!chg_en && !dsg_en));                        // R9
   AST_TRIP_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && |expire) |=> (!dsg_en && !warn_n));               // R3
endmodule

// File: tb/tb_oc_trip_timer.sv
module tb_oc_trip_timer;
   localparam int unsigned LOW_DLY  = 70;
   localparam int unsigned HIGH_DLY = 5;

   logic clk = 1'b0;
   logic rst_n, tick, oc_low, oc_high, pack_hi, remote_off;
   logic dsg_en, chg_en, warn_n, shutdown;

   int checks = 0;
   int fails  = 0;
   bit model_on = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   oc_trip_timer #(.LOW_DLY(LOW_DLY), .HIGH_DLY(HIGH_DLY)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .oc_low(oc_low),
      .oc_high(oc_high), .pack_hi(pack_hi), .remote_off(remote_off),
      .dsg_en(dsg_en), .chg_en(chg_en), .warn_n(warn_n), .shutdown(shutdown)
   );

   // Reference model from the requirements: 0 run, 1 tripped, 2 shutdown
   int m_st = 0;
   int m_lc = 0;
   int m_hc = 0;
   always @(posedge clk) begin
      bit trip;
      trip = 1'b0;
      if (!rst_n) begin
         m_st = 0; m_lc = 0; m_hc = 0;
      end else if (m_st == 0) begin
         if (!oc_low) m_lc = 0;
         else if (tick) begin
            if (m_lc == LOW_DLY - 1) trip = 1'b1; else m_lc++;
         end
         if (!oc_high) m_hc = 0;
         else if (tick) begin
            if (m_hc == HIGH_DLY - 1) trip = 1'b1; else m_hc++;
         end
         if (trip) begin m_st = 1; m_lc = 0; m_hc = 0; end
      end else if (m_st == 1) begin
         if (!pack_hi) m_st = 2;
      end else begin
         if (pack_hi) m_st = 0;
      end
   end

   function automatic bit exp_dsg(int st, bit roff);
      return (st == 0) && !roff;
   endfunction

   task automatic chk(bit got, bit exp, string req, string what);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick = 1'b1; oc_low = 1'b0; oc_high = 1'b0;
      pack_hi = 1'b1; remote_off = 1'b0;
      step(2);
      rst_n = 1'b1;
      step(1);
   endtask

   task automatic recover();
      oc_low = 1'b0; oc_high = 1'b0;
      pack_hi = 1'b0; step(1);
      pack_hi = 1'b1; step(1);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset();
      chk(dsg_en, 1'b1, "R1", "dsg_en after reset");
      chk(chg_en, 1'b1, "R1", "chg_en after reset");
      chk(warn_n, 1'b1, "R1", "warn_n after reset");
      chk(shutdown, 1'b0, "R1", "shutdown after reset");

      // R5: severe pulse one tick short
      oc_low = 1'b1; oc_high = 1'b1; step(HIGH_DLY - 1);
      oc_low = 1'b0; oc_high = 1'b0; step(2);
      chk(dsg_en, 1'b1, "R5", "short severe pulse dsg_en");
      chk(warn_n, 1'b1, "R5", "short severe pulse warn_n");

      // R3: severe trip overtakes a running moderate count
      oc_low = 1'b1; step(10);
      oc_high = 1'b1; step(HIGH_DLY - 1);
      chk(dsg_en, 1'b1, "R3", "one tick before severe trip");
      step(1);
      chk(dsg_en, 1'b0, "R3", "severe trip dsg_en");
      chk(warn_n, 1'b0, "R3", "severe trip warn_n");

      // R6: trip holds with flags gone and pack high
      oc_low = 1'b0; oc_high = 1'b0; step(5);
      chk(dsg_en, 1'b0, "R6", "trip held dsg_en");
      chk(shutdown, 1'b0, "R6", "no shutdown while pack high");

      // R7 then R8
      pack_hi = 1'b0; step(1);
      chk(shutdown, 1'b1, "R7", "shutdown after pack low");
      chk(dsg_en, 1'b0, "R7", "dsg_en in shutdown");
      pack_hi = 1'b1; step(1);
      chk(shutdown, 1'b0, "R8", "shutdown cleared");
      chk(dsg_en, 1'b1, "R8", "dsg_en restored");
      chk(warn_n, 1'b1, "R8", "warn_n restored");

      // R4: cancelled moderate episode, then a full one (R2)
      oc_low = 1'b1; step(LOW_DLY - 1);
      oc_low = 1'b0; step(1);
      oc_low = 1'b1; step(LOW_DLY - 1);
      chk(dsg_en, 1'b1, "R4", "restarted count not yet done");
      step(1);
      chk(dsg_en, 1'b0, "R2", "moderate trip dsg_en");
      chk(warn_n, 1'b0, "R2", "moderate trip warn_n");
      recover();

      // R10: no ticks, no progress
      oc_low = 1'b1; tick = 1'b0; step(200);
      chk(dsg_en, 1'b1, "R10", "no trip without ticks");
      tick = 1'b1; step(LOW_DLY);
      chk(dsg_en, 1'b0, "R10", "trip after ticks resume");
      recover();

      // R9: remote off gates enables, detection continues
      remote_off = 1'b1; step(1);
      chk(chg_en, 1'b0, "R9", "chg_en under remote off");
      chk(dsg_en, 1'b0, "R9", "dsg_en under remote off");
      chk(warn_n, 1'b1, "R9", "warn_n under remote off");
      oc_high = 1'b1; step(HIGH_DLY);
      chk(warn_n, 1'b0, "R9", "trip while remote off");
      recover();
      remote_off = 1'b0; step(1);
      chk(chg_en, 1'b1, "R9", "chg_en after remote on");
      chk(dsg_en, 1'b1, "R9", "dsg_en after remote on");

      // Random phase against the reference model
      do_reset();
      model_on = 1'b1;
      for (int c = 0; c < 4000; c++) begin
         tick = ($urandom % 3) != 0;
         if ($urandom % 40 == 0) oc_low = ~oc_low;
         if ($urandom % 12 == 0) oc_high = oc_low ? ~oc_high : 1'b0;
         if (!oc_low) oc_high = 1'b0;
         if ($urandom % 25 == 0) pack_hi = ~pack_hi;
         if ($urandom % 60 == 0) remote_off = ~remote_off;
         step(1);
         chk(dsg_en, exp_dsg(m_st, remote_off), "R2", "random dsg_en");
         chk(warn_n, m_st == 0, "R6", "random warn_n");
         chk(shutdown, m_st == 2, "R7", "random shutdown");
         chk(chg_en, !remote_off, "R9", "random chg_en");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule